// File: doc/BRIEF.md
# Timer Capture, Compare and PWM Channel

This channel sits beside a free-running 16-bit timer. It holds one 16-bit data register, and the mode decides what that register means. In capture modes the register latches the timer when the input pin shows a chosen edge. In compare modes the register is the match value, and a match drives the output pin, raises an event or resets the timer. In PWM mode the low byte of the register is the upper part of a 10-bit duty cycle.

Software writes a control byte and the data register through plain write strobes. The control byte holds a 4-bit mode code in bits 3:0 and the two low duty bits in bits 5:4. The channel returns the interrupt-flag set pulse, a one-clock timer-reset pulse and a one-clock conversion-start pulse to the surrounding chip. In PWM mode the channel counts its own 10-bit period. The 8-bit period input is extended by two low bits that run from 0 to 3, so one period lasts (period+1)*4 clocks.

Top module: `ccp_channel`

## Requirements
- R1: Mode codes 0000, 0001 and 0011 disable the channel. The pin output and its enable stay low, no flag, timer-reset or conversion pulse is produced, and the edge prescaler and PWM counter are cleared.
- R2: Mode 0101 captures on each rising edge and mode 0100 on each falling edge of the pin input. The input passes a two-flop synchronizer and an edge detector. The data register takes the value of timer_i sampled at the edge where the edge is detected (two edges after the first edge that samples the new level). flag_o is high for one clock in the cycle after that edge.
- R3: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Any write of the control byte restarts the edge count from zero.
- R4: Mode 0010 toggles the pin when timer_i first equals the data register. While the equality persists, no further flag or toggle occurs.
- R5: Mode 1000 drives the pin low on entry and high on a match. Mode 1001 drives it high on entry and low on a match. Each match pulses flag_o.
- R6: Mode 1010 only pulses flag_o on a match and leaves pin_oe_o low. Mode 1011 pulses flag_o, tmr_rst_o and conv_o together for exactly one clock on a match.
- R7: Every mode code 11xx is PWM. The duty is {data[7:0], ctrl[5:4]}. The pin is high while the 10-bit period count is below the duty, so each period has min(duty, (period+1)*4) high clocks. A duty of 0 keeps the pin low.
- R8: A new duty value takes effect only at the period rollover. The active period always finishes with the duty it started with.
- R9: Control bits 7:6 read back as zero whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wd_i | input | 8 | Control byte write data |
| data_we_i | input | 1 | Data register write strobe |
| data_wd_i | input | 16 | Data register write data |
| timer_i | input | 16 | Free-running timer value |
| period_i | input | 8 | PWM period, upper bits |
| pin_i | input | 1 | Asynchronous capture input pin |
| pin_o | output | 1 | Output pin level |
| pin_oe_o | output | 1 | Output pin driven by the channel |
| flag_o | output | 1 | One-clock interrupt-flag set pulse |
| tmr_rst_o | output | 1 | One-clock timer-reset pulse |
| conv_o | output | 1 | One-clock conversion-start pulse |
| ctrl_q_o | output | 8 | Control byte read-back |
| data_q_o | output | 16 | Data register read-back |

## Verification
The assertions check on every clock that disabled codes stay quiet, that a capture flag comes with the timer value of the previous cycle, that a lasting equality fires only once, that the set and clear modes leave the pin at the right level after a match, and that the special-event pulses are single clocks tied to the flag. The prescaler counts, the restart of the count on a control write, the duty in high clocks per period, and the deferral of a new duty to the rollover can only be shown by the bench scenarios. Those scenarios measure them against the bench's own cycle model.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

   typedef enum logic [1:0] {
      FN_OFF = 2'd0,
      FN_CAP = 2'd1,
      FN_CMP = 2'd2,
      FN_PWM = 2'd3
   } ccp_fn_e;

   localparam logic [3:0] MD_TOGGLE     = 4'b0010;
   localparam logic [3:0] MD_CAP_FALL   = 4'b0100;
   localparam logic [3:0] MD_CAP_RISE   = 4'b0101;
   localparam logic [3:0] MD_CAP_DIV_LO = 4'b0110;
   localparam logic [3:0] MD_CAP_DIV_HI = 4'b0111;
   localparam logic [3:0] MD_SET_HIGH   = 4'b1000;
   localparam logic [3:0] MD_SET_LOW    = 4'b1001;
   localparam logic [3:0] MD_FLAG_ONLY  = 4'b1010;
   localparam logic [3:0] MD_EVENT      = 4'b1011;

   function automatic ccp_fn_e mode_fn(input logic [3:0] m);
      if (m[3:2] == 2'b11)      return FN_PWM;
      else if (m[3:2] == 2'b01) return FN_CAP;
      else if (m[3])            return FN_CMP;
      else if (m == MD_TOGGLE)  return FN_CMP;
      else                      return FN_OFF;
   endfunction

   function automatic logic cmp_drives_pin(input logic [3:0] m);
      return (m == MD_TOGGLE) || (m == MD_SET_HIGH) || (m == MD_SET_LOW);
   endfunction

endpackage

// File: rtl/ccp_insync.sv
module ccp_insync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ccp_insync: STAGES must be at least 2");
   end

   logic [STAGES:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[STAGES-1:0], pin_i};
   end

   assign rise_o =  stage_q[STAGES-1] & ~stage_q[STAGES];
   assign fall_o = ~stage_q[STAGES-1] &  stage_q[STAGES];
endmodule

// File: rtl/ccp_cap_presc.sv
module ccp_cap_presc
   import ccp_pkg::*;
#(
   parameter int DIV_LO = 4,
   parameter int DIV_HI = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic [3:0] mode_i,
   input  logic       rise_i,
   input  logic       fall_i,
   output logic       hit_o
);
   localparam int CNT_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;
   localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(DIV_LO - 1);
   localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(DIV_HI - 1);

   if (DIV_LO < 2 || DIV_HI < DIV_LO) begin : g_bad_div
      $error("ccp_cap_presc: need 2 <= DIV_LO <= DIV_HI");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic             div_sel;
   logic             wrap;

   always_comb begin
      div_sel = (mode_i == MD_CAP_DIV_LO) || (mode_i == MD_CAP_DIV_HI);
      lim     = (mode_i == MD_CAP_DIV_HI) ? LIM_HI : LIM_LO;
      wrap    = div_sel && rise_i && (cnt_q == lim);
      hit_o   = ((mode_i == MD_CAP_FALL) && fall_i)
             || ((mode_i == MD_CAP_RISE) && rise_i)
             || wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr_i)             cnt_q <= '0;
      else if (div_sel && rise_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/ccp_cmp_unit.sv
module ccp_cmp_unit
   import ccp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic         entry_i,
   input  logic [3:0]   mode_i,
   input  logic [W-1:0] timer_i,
   input  logic [W-1:0] ref_i,
   output logic         fire_o,
   output logic         pin_o
);
   logic eq;
   logic seen_q;
   logic pin_q;

   assign eq     = (timer_i == ref_i);
   assign fire_o = en_i && eq && !seen_q;
   assign pin_o  = pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= en_i && eq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else if (!en_i) begin
         pin_q <= 1'b0;
      end else if (entry_i) begin
         if (mode_i == MD_SET_HIGH)     pin_q <= 1'b0;
         else if (mode_i == MD_SET_LOW) pin_q <= 1'b1;
      end else if (fire_o) begin
         case (mode_i)
            MD_TOGGLE:   pin_q <= ~pin_q;
            MD_SET_HIGH: pin_q <= 1'b1;
            MD_SET_LOW:  pin_q <= 1'b0;
            default:     pin_q <= pin_q;
         endcase
      end
   end
endmodule

// File: rtl/ccp_pwm_gen.sv
module ccp_pwm_gen #(
   parameter int PER_W  = 8,
   parameter int FRAC_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en_i,
   input  logic [PER_W-1:0]        period_i,
   input  logic [PER_W+FRAC_W-1:0] duty_i,
   output logic                    level_o
);
   localparam int CNT_W = PER_W + FRAC_W;

   if (FRAC_W < 1 || PER_W < 1) begin : g_bad_width
      $error("ccp_pwm_gen: PER_W and FRAC_W must be positive");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] duty_q;
   logic             last;

   assign last    = (cnt_q == {period_i, {FRAC_W{1'b1}}});
   assign level_o = en_i && (cnt_q < duty_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         duty_q <= '0;
      end else if (!en_i || last) begin
         cnt_q  <= '0;
         duty_q <= duty_i;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
   import ccp_pkg::*;
#(
   parameter int TMR_W     = 16,
   parameter int PER_W     = 8,
   parameter int SYNC_STG  = 2,
   parameter int DIV_LO    = 4,
   parameter int DIV_HI    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we_i,
   input  logic [7:0]       ctrl_wd_i,
   input  logic             data_we_i,
   input  logic [TMR_W-1:0] data_wd_i,
   input  logic [TMR_W-1:0] timer_i,
   input  logic [PER_W-1:0] period_i,
   input  logic             pin_i,
   output logic             pin_o,
   output logic             pin_oe_o,
   output logic             flag_o,
   output logic             tmr_rst_o,
   output logic             conv_o,
   output logic [7:0]       ctrl_q_o,
   output logic [TMR_W-1:0] data_q_o
);
   localparam int FRAC_W = 2;
   localparam int DUTY_W = PER_W + FRAC_W;

   if (TMR_W < PER_W) begin : g_bad_tmr
      $error("ccp_channel: TMR_W must not be below PER_W");
   end

   logic [3:0]       mode_q;
   logic [3:0]       mode_prev_q;
   logic [1:0]       frac_q;
   logic [TMR_W-1:0] data_q;
   logic             flag_q, trst_q, conv_q;
   ccp_fn_e          fn;
   logic             entry;
   logic             rise, fall;
   logic             presc_hit, cap_hit;
   logic             cmp_fire, cmp_pin;
   logic             pwm_level;
   logic [DUTY_W-1:0] duty_new;
   logic             unused_ctrl;

   assign unused_ctrl = ^ctrl_wd_i[7:6];
   assign fn          = mode_fn(mode_q);
   assign entry       = (mode_q != mode_prev_q);
   assign cap_hit     = (fn == FN_CAP) && presc_hit;
   assign duty_new    = {data_q[PER_W-1:0], frac_q};

   ccp_insync #(.STAGES(SYNC_STG)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .rise_o (rise),
      .fall_o (fall)
   );

   ccp_cap_presc #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (ctrl_we_i || (fn != FN_CAP)),
      .mode_i (mode_q),
      .rise_i (rise),
      .fall_i (fall),
      .hit_o  (presc_hit)
   );

   ccp_cmp_unit #(.W(TMR_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (fn == FN_CMP),
      .entry_i (entry),
      .mode_i  (mode_q),
      .timer_i (timer_i),
      .ref_i   (data_q),
      .fire_o  (cmp_fire),
      .pin_o   (cmp_pin)
   );

   ccp_pwm_gen #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_pwm (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (fn == FN_PWM),
      .period_i (period_i),
      .duty_i   (duty_new),
      .level_o  (pwm_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= '0;
         frac_q      <= '0;
         mode_prev_q <= '0;
      end else begin
         mode_prev_q <= mode_q;
         if (ctrl_we_i) begin
            mode_q <= ctrl_wd_i[3:0];
            frac_q <= ctrl_wd_i[5:4];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         data_q <= '0;
      else if (cap_hit)   data_q <= timer_i;
      else if (data_we_i) data_q <= data_wd_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         trst_q <= 1'b0;
         conv_q <= 1'b0;
      end else begin
         flag_q <= cmp_fire || cap_hit;
         trst_q <= cmp_fire && (mode_q == MD_EVENT);
         conv_q <= cmp_fire && (mode_q == MD_EVENT);
      end
   end

   always_comb begin
      if (fn == FN_PWM) begin
         pin_o    = pwm_level;
         pin_oe_o = 1'b1;
      end else begin
         pin_oe_o = (fn == FN_CMP) && cmp_drives_pin(mode_q);
         pin_o    = pin_oe_o && cmp_pin;
      end
   end

   assign flag_o    = flag_q;
   assign tmr_rst_o = trst_q;
   assign conv_o    = conv_q;
   assign ctrl_q_o  = {2'b00, frac_q, mode_q};
   assign data_q_o  = data_q;
endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk #(
   parameter int TMR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       ctrl_q_o,
   input logic [TMR_W-1:0] timer_i,
   input logic [TMR_W-1:0] data_q_o,
   input logic             pin_o,
   input logic             pin_oe_o,
   input logic             flag_o,
   input logic             tmr_rst_o,
   input logic             conv_o
);
   logic [3:0] md;
   logic       md_off, md_cmp, md_cap, eq;

   assign md     = ctrl_q_o[3:0];
   assign md_off = (md == 4'b0000) || (md == 4'b0001) || (md == 4'b0011);
   assign md_cmp = (md == 4'b0010) || (md[3:2] == 2'b10);
   assign md_cap = (md[3:2] == 2'b01);
   assign eq     = (timer_i == data_q_o);

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      md_off && $past(md_off) |-> !flag_o && !tmr_rst_o && !conv_o && !pin_oe_o && !pin_o); // R1

   AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(md_cap) && flag_o |-> data_q_o == $past(timer_i)); // R2

   AST_CMP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      md_cmp && $past(md_cmp) && eq && $past(eq) |=> !flag_o); // R4

   AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      md == 4'b1000 && $past(md) == 4'b1000 && $past(md, 2) == 4'b1000 && flag_o |-> pin_o); // R5

   AST_SET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      md == 4'b1001 && $past(md) == 4'b1001 && $past(md, 2) == 4'b1001 && flag_o |-> !pin_o); // R5

   AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_rst_o |=> !tmr_rst_o && !conv_o); // R6

   AST_EVT_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_rst_o |-> flag_o && conv_o); // R6

   AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe_o |-> !pin_o); // R6
endmodule

bind ccp_channel ccp_channel_chk #(.TMR_W(TMR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_q_o  (ctrl_q_o),
   .timer_i   (timer_i),
   .data_q_o  (data_q_o),
   .pin_o     (pin_o),
   .pin_oe_o  (pin_oe_o),
   .flag_o    (flag_o),
   .tmr_rst_o (tmr_rst_o),
   .conv_o    (conv_o)
);

// File: tb/ccp_channel_tb.sv
module ccp_channel_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [7:0]  ctrl_wd = '0;
   logic        data_we = 1'b0;
   logic [15:0] data_wd = '0;
   logic [15:0] tmr_v = '0;
   logic [7:0]  period_v = 8'd3;
   logic        pin_v = 1'b0;
   logic        tmr_run = 1'b0;
   logic        pin_o, pin_oe_o, flag_o, tmr_rst_o, conv_o;
   logic [7:0]  ctrl_q_o;
   logic [15:0] data_q_o;

   int checks = 0, errors = 0, cyc = 0;
   int n_flag = 0, n_trst = 0, n_conv = 0, n_high = 0;

   // reference model state
   int m_ctrl, m_data, m_s1, m_s2, m_s3, m_pc, m_mprev, m_mq, m_cpin;
   int m_flag, m_trst, m_conv, m_cnt, m_dact;

   always #5 clk = ~clk;

   ccp_channel dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wd_i(ctrl_wd),
      .data_we_i(data_we), .data_wd_i(data_wd), .timer_i(tmr_v),
      .period_i(period_v), .pin_i(pin_v), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
      .flag_o(flag_o), .tmr_rst_o(tmr_rst_o), .conv_o(conv_o),
      .ctrl_q_o(ctrl_q_o), .data_q_o(data_q_o));

   function automatic int fn_of(int m);
      if ((m >> 2) == 3) return 3;
      if ((m >> 2) == 1) return 1;
      if (m >= 8 || m == 2) return 2;
      return 0;
   endfunction

   function automatic int drv(int m);
      return (m == 2 || m == 8 || m == 9) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_data = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pc = 0;
         m_mprev = 0; m_mq = 0; m_cpin = 0; m_flag = 0; m_trst = 0;
         m_conv = 0; m_cnt = 0; m_dact = 0;
      end else begin
         int mode, f, eq, rise, fall, cap, dv, npc, fire, entry, ncp, dnew;
         mode = m_ctrl & 15; f = fn_of(mode); eq = (int'(tmr_v) == m_data);
         rise = m_s2 && !m_s3; fall = !m_s2 && m_s3;
         cap = 0; npc = m_pc;
         dv = (mode == 6) ? 4 : (mode == 7) ? 16 : 0;
         if (f == 1) begin
            if (mode == 4 && fall) cap = 1;
            if (mode == 5 && rise) cap = 1;
            if (dv != 0 && rise) begin
               if (m_pc == dv - 1) begin cap = 1; npc = 0; end
               else npc = m_pc + 1;
            end
         end
         if (ctrl_we || f != 1) npc = 0;
         fire = (f == 2) && eq && !m_mq;
         entry = (mode != m_mprev);
         ncp = m_cpin;
         if (f != 2) ncp = 0;
         else if (entry) begin
            if (mode == 8) ncp = 0;
            if (mode == 9) ncp = 1;
         end else if (fire) begin
            if (mode == 2) ncp = 1 - m_cpin;
            if (mode == 8) ncp = 1;
            if (mode == 9) ncp = 0;
         end
         dnew = ((m_data & 255) << 2) | ((m_ctrl >> 4) & 3);
         if (f == 3 && m_cnt != int'(period_v) * 4 + 3) m_cnt = m_cnt + 1;
         else begin m_cnt = 0; m_dact = dnew; end
         if (cap) m_data = int'(tmr_v);
         else if (data_we) m_data = int'(data_wd);
         if (ctrl_we) m_ctrl = int'(ctrl_wd) & 'h3F;
         m_flag = fire || cap; m_trst = fire && mode == 11; m_conv = m_trst;
         m_mq = (f == 2) ? eq : 0;
         m_mprev = mode; m_pc = npc; m_cpin = ncp;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(pin_v);
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         int mode, f, ep, eoe;
         string tag;
         mode = m_ctrl & 15; f = fn_of(mode);
         eoe = (f == 3) ? 1 : (f == 2 ? drv(mode) : 0);
         ep  = (f == 3) ? int'(m_cnt < m_dact) : (eoe ? m_cpin : 0);
         tag = (f == 0) ? "R1" : (f == 1) ? "R2" : (f == 2) ? "R4" : "R7";
         if (f == 3 && m_dact != (((m_data & 255) << 2) | ((m_ctrl >> 4) & 3))) tag = "R8";
         checks++;
         if (int'(pin_o) != ep || int'(pin_oe_o) != eoe || int'(flag_o) != m_flag ||
             int'(tmr_rst_o) != m_trst || int'(conv_o) != m_conv ||
             int'(data_q_o) != m_data || int'(ctrl_q_o) != m_ctrl) begin
            errors++;
            $display("FAIL %s cycle %0d: act pin=%0d oe=%0d flag=%0d trst=%0d conv=%0d data=%0d ctrl=%0h exp pin=%0d oe=%0d flag=%0d trst=%0d conv=%0d data=%0d ctrl=%0h",
                     tag, cyc, pin_o, pin_oe_o, flag_o, tmr_rst_o, conv_o, data_q_o, ctrl_q_o,
                     ep, eoe, m_flag, m_trst, m_conv, m_data, m_ctrl);
         end
         if (flag_o) n_flag++;
         if (tmr_rst_o) n_trst++;
         if (conv_o) n_conv++;
         if (pin_o) n_high++;
      end
   end

   always @(negedge clk) if (tmr_run) tmr_v <= tmr_v + 16'd1;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 50000) begin
         errors++;
         $display("FAIL watchdog: act running exp finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      ctrl_wd = v; ctrl_we = 1'b1; tick(1); ctrl_we = 1'b0;
   endtask

   task automatic wr_data(input logic [15:0] v);
      data_wd = v; data_we = 1'b1; tick(1); data_we = 1'b0;
   endtask

   task automatic clr_counts();
      n_flag = 0; n_trst = 0; n_conv = 0; n_high = 0;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin pin_v = 1'b1; tick(3); pin_v = 1'b0; tick(3); end
   endtask

   task automatic rematch(input logic [15:0] v);
      tmr_v = v + 16'd7; tick(2); tmr_v = v; tick(3);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: act %0d exp %0d", tag, act, exp);
      end
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R1 reset ctrl", ctrl_q_o, 0);
      chk("R1 reset data", data_q_o, 0);
      chk("R1 reset oe", pin_oe_o, 0);

      wr_ctrl(8'hC0); tick(1); chk("R9 top bits", ctrl_q_o, 8'h00);
      wr_ctrl(8'hF0); tick(1); chk("R9 top bits", ctrl_q_o, 8'h30);
      wr_ctrl(8'h00);

      // R2 rising then falling with a held timer
      tmr_v = 16'd1234; wr_ctrl(8'h05); clr_counts();
      pin_v = 1'b1; tick(5);
      chk("R2 rise value", data_q_o, 1234); chk("R2 rise flags", n_flag, 1);
      tmr_v = 16'd777; wr_ctrl(8'h04); clr_counts();
      pin_v = 1'b0; tick(5);
      chk("R2 fall value", data_q_o, 777); chk("R2 fall flags", n_flag, 1);

      // R3 prescaled capture
      tmr_run = 1'b1; wr_ctrl(8'h06); clr_counts();
      pulses(8); tick(4); chk("R3 div4", n_flag, 2);
      clr_counts(); pulses(2); wr_ctrl(8'h06); pulses(3); tick(4);
      chk("R3 restart", n_flag, 0);
      pulses(1); tick(4); chk("R3 restart hit", n_flag, 1);
      wr_ctrl(8'h07); clr_counts(); pulses(16); tick(4); chk("R3 div16", n_flag, 1);
      tmr_run = 1'b0;

      // R4 toggle, once per equality run
      wr_ctrl(8'h00); wr_data(16'd500); tmr_v = 16'd499;
      wr_ctrl(8'h02); tick(2); clr_counts();
      tmr_v = 16'd500; tick(6);
      chk("R4 single fire", n_flag, 1); chk("R4 toggled", pin_o, 1);

      // R5 set / clear modes
      wr_ctrl(8'h08); tick(1); chk("R5 entry low", pin_o, 0);
      rematch(16'd500); chk("R5 forced high", pin_o, 1);
      wr_ctrl(8'h09); tick(1); chk("R5 entry high", pin_o, 1);
      rematch(16'd500); chk("R5 forced low", pin_o, 0);

      // R6 flag only, special event
      wr_ctrl(8'h0A); clr_counts(); rematch(16'd500);
      chk("R6 flag only", n_flag, 1); chk("R6 undriven", pin_oe_o, 0);
      wr_ctrl(8'h0B); clr_counts(); rematch(16'd500);
      chk("R6 timer reset", n_trst, 1); chk("R6 conversion", n_conv, 1);
      chk("R6 event flag", n_flag, 1);

      // R1 disabled and reserved codes
      for (int k = 0; k < 3; k++) begin
         wr_ctrl((k == 0) ? 8'h01 : (k == 1) ? 8'h03 : 8'h00);
         tick(1); clr_counts(); rematch(16'd500); pulses(2);
         chk("R1 no flag", n_flag, 0); chk("R1 no event", n_trst + n_conv, 0);
         chk("R1 no drive", pin_oe_o, 0);
      end

      // R7 / R8 PWM, period 3 -> 16 clocks
      period_v = 8'd3; wr_data(16'd2); wr_ctrl(8'h1C); tick(20);
      clr_counts(); tick(32); chk("R7 duty 9", n_high, 18);
      wr_data(16'd1); tick(20); clr_counts(); tick(32); chk("R8 new duty 5", n_high, 10);
      wr_ctrl(8'h1F); tick(20); clr_counts(); tick(32); chk("R7 code 1111", n_high, 10);
      wr_data(16'd0); wr_ctrl(8'h0D); tick(20); clr_counts(); tick(32);
      chk("R7 zero duty", n_high, 0);
      wr_data(16'h00FF); wr_ctrl(8'h3E); tick(20); clr_counts(); tick(32);
      chk("R7 duty over period", n_high, 32);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule